// File: doc/BRIEF.md
# Phase-Shifted Full-Bridge Gate Command Generator

This block drives the four switches of a full bridge. Each bridge leg is a complementary pair of switches. A leg flip-flop selects which switch of the pair is commanded on. Both leg flip-flops toggle at a fixed rate, so every switch runs at a constant frequency with close to 50% duty.

Leg A toggles on every switching event. Each event also starts a pulse whose length is the requested width, and leg B toggles when that pulse ends. The width therefore sets how far leg B lags leg A. It does not set any on-time. Power reaches the load only while diagonal switches overlap: A-high with B-low, or A-low with B-high. So the lag is the control quantity, and it runs from zero up to just under a half period.

Each leg has its own turn-on delay to form a dead band, and the two delays are set independently. Turn-off is never delayed.

Top module: `psfb_gen`

## Requirements
- R1: While `rst` is high at a clock edge, all four outputs are low after that edge. After reset, both legs start with their low-side switches selected, so `a_lo_o` and `b_lo_o` rise one cycle after `rst` falls and the high-side outputs stay low.
- R2: The half period is `H = period_i >> 1`, raised to 2 when smaller. The first edge after reset with `rst` low is a switching event. Further events follow every `H` cycles, and leg A toggles at each of these later events, which gives a switching period of `2*H` cycles.
- R3: At each event the width is clamped to `W = min(width_i, H-1)`. Leg B toggles exactly `W` cycles after leg A.
- R4: With `W = 0`, leg B toggles on the same edge as leg A, and both legs keep switching in phase.
- R5: `period_i` and `width_i` are sampled only at switching events. Changes between events have no effect until the next event.
- R6: Turn-off is immediate. One cycle after a leg flip-flop changes, the switch it deselects is off.
- R7: The incoming switch of a leg turns on `D` cycles after the outgoing one turns off, where `D` is that leg's dead count, and 0 means no gap. This holds even when `D` exceeds the half period. The high and low outputs of one leg are never both high.
- R8: `dead_a_i` applies only to leg A and `dead_b_i` only to leg B.
- R9: A width of `H-1` or more gives the largest diagonal overlap, `H-1` cycles per half period less the dead band. This makes the full control range reachable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| period_i | input | CNT_W | Switching period in clocks; bit 0 ignored |
| width_i | input | CNT_W | Requested lag of leg B behind leg A, in clocks |
| dead_a_i | input | DT_W | Turn-on delay for leg A switches, in clocks |
| dead_b_i | input | DT_W | Turn-on delay for leg B switches, in clocks |
| a_hi_o | output | 1 | Leg A high-side command |
| a_lo_o | output | 1 | Leg A low-side command |
| b_hi_o | output | 1 | Leg B high-side command |
| b_lo_o | output | 1 | Leg B low-side command |

## Verification
The hardest situation to reach from the ports is a width or period change that lands between two events. The old value must remain in force until the next event, while a lag countdown may already be running. To get there, the stimulus rewrites `width_i` and `period_i` every few cycles at positions that do not line up with the event spacing, and the reference model applies the new values only at events. A second case is a dead count longer than the half period, where a leg toggles again before its incoming switch ever turns on. A short period combined with a long leg-A dead count produces it.

// File: rtl/psfb_pkg.sv
package psfb_pkg;

  // Gate command pair for one bridge leg.
  typedef struct packed {
    logic hi;
    logic lo;
  } gate_pair_t;

  localparam int NUM_LEGS = 2;

endpackage

// File: rtl/psfb_timebase.sv
module psfb_timebase #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] width_i,
  output logic             toggle_o,
  output logic [CNT_W-1:0] wid_o
);

  localparam logic [CNT_W-1:0] HALF_MIN = CNT_W'(2);
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  logic             run_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] half_q;
  logic [CNT_W-1:0] half_raw;
  logic [CNT_W-1:0] half_next;
  logic [CNT_W-1:0] wid_max;
  logic             ev;

  // Half period derived from the full period; never shorter than two clocks.
  always_comb begin
    half_raw  = {1'b0, period_i[CNT_W-1:1]};
    half_next = (half_raw < HALF_MIN) ? HALF_MIN : half_raw;
    wid_max   = half_next - ONE;
    wid_o     = (width_i > wid_max) ? wid_max : width_i;
    ev        = !run_q || (cnt_q == half_q - ONE);
  end

  // Period and width are taken only at a switching event.
  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      half_q <= HALF_MIN;
    end else if (ev) begin
      run_q  <= 1'b1;
      cnt_q  <= '0;
      half_q <= half_next;
    end else begin
      cnt_q  <= cnt_q + ONE;
    end
  end

  // The first event after reset only starts the timebase.
  assign toggle_o = ev && run_q;

  a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
    cnt_q < half_q);

  a_r2_half_floor: assert property (@(posedge clk) disable iff (rst)
    half_q >= HALF_MIN);

endmodule

// File: rtl/psfb_legs.sv
module psfb_legs #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             toggle_i,
  input  logic [CNT_W-1:0] wid_i,
  output logic             leg_a_o,
  output logic             leg_b_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             leg_a_q;
  logic             leg_b_q;
  logic [CNT_W-1:0] lag_q;

  // Leg A follows the event. Leg B follows the end of the lag pulse.
  always_ff @(posedge clk) begin
    if (rst) begin
      leg_a_q <= 1'b0;
      leg_b_q <= 1'b0;
      lag_q   <= '0;
    end else if (toggle_i) begin
      leg_a_q <= ~leg_a_q;
      lag_q   <= wid_i;
      if (wid_i == '0) begin
        leg_b_q <= ~leg_b_q;
      end
    end else if (lag_q != '0) begin
      lag_q <= lag_q - ONE;
      if (lag_q == ONE) begin
        leg_b_q <= ~leg_b_q;
      end
    end
  end

  assign leg_a_o = leg_a_q;
  assign leg_b_o = leg_b_q;

  // Leg B has caught up before every event (R3).
  a_r3_lag_done: assert property (@(posedge clk) disable iff (rst)
    toggle_i |-> (lag_q == '0) && (leg_a_q == leg_b_q));

  // Zero width keeps the legs in phase (R4).
  a_r4_in_phase: assert property (@(posedge clk) disable iff (rst)
    (toggle_i && (wid_i == '0)) |=> (leg_a_q == leg_b_q));

endmodule

// File: rtl/psfb_deadband.sv
module psfb_deadband
  import psfb_pkg::*;
#(
  parameter int DT_W = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            leg_i,
  input  logic [DT_W-1:0] dead_i,
  output gate_pair_t      gate_o
);

  localparam logic [DT_W-1:0] ONE = DT_W'(1);

  logic            prev_q;
  logic [DT_W-1:0] hold_q;
  gate_pair_t      gate_q;

  // Turn-off is immediate. Turn-on waits dead_i cycles.
  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      hold_q <= '0;
      gate_q <= '0;
    end else if (leg_i != prev_q) begin
      prev_q <= leg_i;
      if (dead_i == '0) begin
        hold_q    <= '0;
        gate_q.hi <= leg_i;
        gate_q.lo <= ~leg_i;
      end else begin
        hold_q <= dead_i - ONE;
        gate_q <= '0;
      end
    end else if (hold_q != '0) begin
      hold_q <= hold_q - ONE;
      gate_q <= '0;
    end else begin
      gate_q.hi <= leg_i;
      gate_q.lo <= ~leg_i;
    end
  end

  assign gate_o = gate_q;

  a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(gate_q.hi && gate_q.lo));

  a_r6_fast_off: assert property (@(posedge clk) disable iff (rst)
    (leg_i != prev_q) |=> (prev_q ? !gate_q.lo : !gate_q.hi));

  a_r7_gap_open: assert property (@(posedge clk) disable iff (rst)
    ((leg_i != prev_q) && (dead_i != '0)) |=> (!gate_q.hi && !gate_q.lo));

endmodule

// File: rtl/psfb_gen.sv
module psfb_gen
  import psfb_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int DT_W  = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] width_i,
  input  logic [DT_W-1:0]  dead_a_i,
  input  logic [DT_W-1:0]  dead_b_i,
  output logic             a_hi_o,
  output logic             a_lo_o,
  output logic             b_hi_o,
  output logic             b_lo_o
);

  logic             toggle;
  logic [CNT_W-1:0] wid;
  logic [NUM_LEGS-1:0] leg;
  logic [DT_W-1:0]  dead [NUM_LEGS];
  gate_pair_t       gate [NUM_LEGS];

  psfb_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk      (clk),
    .rst      (rst),
    .period_i (period_i),
    .width_i  (width_i),
    .toggle_o (toggle),
    .wid_o    (wid)
  );

  psfb_legs #(.CNT_W(CNT_W)) u_legs (
    .clk      (clk),
    .rst      (rst),
    .toggle_i (toggle),
    .wid_i    (wid),
    .leg_a_o  (leg[0]),
    .leg_b_o  (leg[1])
  );

  assign dead[0] = dead_a_i;
  assign dead[1] = dead_b_i;

  // One dead-band stage per bridge leg.
  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    psfb_deadband #(.DT_W(DT_W)) u_db (
      .clk    (clk),
      .rst    (rst),
      .leg_i  (leg[g]),
      .dead_i (dead[g]),
      .gate_o (gate[g])
    );
  end

  assign a_hi_o = gate[0].hi;
  assign a_lo_o = gate[0].lo;
  assign b_hi_o = gate[1].hi;
  assign b_lo_o = gate[1].lo;

  a_r1_reset_low: assert property (@(posedge clk)
    rst |=> !(a_hi_o || a_lo_o || b_hi_o || b_lo_o));

endmodule

// File: tb/sim_psfb_gen.sv
module sim_psfb_gen;

  localparam int CLK_P = 10;
  localparam int QTR   = CLK_P / 4;
  localparam int CNT_W = 10;
  localparam int DT_W  = 6;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [CNT_W-1:0] period_i = '0;
  logic [CNT_W-1:0] width_i  = '0;
  logic [DT_W-1:0]  dead_a_i = '0;
  logic [DT_W-1:0]  dead_b_i = '0;
  logic a_hi_o, a_lo_o, b_hi_o, b_lo_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  string cur_req = "R1";

  psfb_gen #(.CNT_W(CNT_W), .DT_W(DT_W)) u0 (
    .clk(clk), .rst(rst), .period_i(period_i), .width_i(width_i),
    .dead_a_i(dead_a_i), .dead_b_i(dead_b_i),
    .a_hi_o(a_hi_o), .a_lo_o(a_lo_o), .b_hi_o(b_hi_o), .b_lo_o(b_lo_o)
  );

  always #(CLK_P/2) clk = ~clk;

  // Reference model state, indexed by edge number since reset.
  int n, h, w, next_ev, b_due, t_a, t_b;
  bit m_a, m_b;

  function automatic int half_of(int p);
    int hv = p / 2;
    return (hv < 2) ? 2 : hv;
  endfunction

  always begin
    bit e_ahi, e_alo, e_bhi, e_blo;
    @(posedge clk);
    #(QTR);
    if (rst) begin
      n = 0; m_a = 0; m_b = 0; t_a = -100000; t_b = -100000; b_due = -1;
      e_ahi = 0; e_alo = 0; e_bhi = 0; e_blo = 0;
    end else begin
      n++;
      e_ahi =  m_a && (n - 1 - t_a >= int'(dead_a_i));
      e_alo = !m_a && (n - 1 - t_a >= int'(dead_a_i));
      e_bhi =  m_b && (n - 1 - t_b >= int'(dead_b_i));
      e_blo = !m_b && (n - 1 - t_b >= int'(dead_b_i));
      if (n == 1) begin
        h = half_of(int'(period_i));
        w = (int'(width_i) > h - 1) ? h - 1 : int'(width_i);
        next_ev = n + h;
      end else if (n == next_ev) begin
        m_a = !m_a; t_a = n;
        h = half_of(int'(period_i));
        w = (int'(width_i) > h - 1) ? h - 1 : int'(width_i);
        next_ev = n + h;
        if (w == 0) begin m_b = !m_b; t_b = n; end
        else b_due = n + w;
      end else if (n == b_due) begin
        m_b = !m_b; t_b = n; b_due = -1;
      end
    end
    checks++;
    if ({a_hi_o, a_lo_o, b_hi_o, b_lo_o} !== {e_ahi, e_alo, e_bhi, e_blo}) begin
      failures++;
      $display("FAIL %s edge=%0d actual=%b%b%b%b expected=%b%b%b%b", cur_req, n,
               a_hi_o, a_lo_o, b_hi_o, b_lo_o, e_ahi, e_alo, e_bhi, e_blo);
    end
    checks++;  // R7: never both switches of one leg on
    if ((a_hi_o === 1'b1 && a_lo_o === 1'b1) || (b_hi_o === 1'b1 && b_lo_o === 1'b1)) begin
      failures++;
      $display("FAIL R7 shoot-through actual=%b%b%b%b expected=no pair high",
               a_hi_o, a_lo_o, b_hi_o, b_lo_o);
    end
  end

  task automatic do_reset(int pa, int wi, int da, int db);
    @(negedge clk);
    rst = 1'b1; cur_req = "R1";
    period_i = CNT_W'(pa); width_i = CNT_W'(wi);
    dead_a_i = DT_W'(da); dead_b_i = DT_W'(db);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic run(string tag, int cyc);
    cur_req = tag;
    repeat (cyc) @(negedge clk);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    // R1 reset, then R2/R3 basic lag with unequal dead counts
    do_reset(20, 4, 2, 3);
    run("R2", 60);
    run("R3", 140);
    // R4 zero width stays in phase
    do_reset(24, 0, 1, 1);
    run("R4", 120);
    // R9 over-range width clamps to H-1 (full range)
    do_reset(20, 50, 1, 2);
    run("R9", 120);
    // R8 separate dead counts, leg A with none
    do_reset(30, 6, 0, 7);
    run("R8", 150);
    // R7 dead count longer than half period; R6 immediate turn-off
    do_reset(8, 2, 15, 1);
    run("R7", 80);
    cur_req = "R6";
    dead_b_i = dead_b_i;
    run("R6", 40);
    // R2 tiny period raises half to 2
    do_reset(2, 3, 0, 0);
    run("R2", 60);
    // R5 inputs rewritten between events
    do_reset(22, 5, 1, 1);
    cur_req = "R5";
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (i % 3 == 0) width_i = CNT_W'((i * 7) % 13);
      if (i % 5 == 0) period_i = CNT_W'(14 + (i % 4) * 4);
    end
    run("R5", 40);
    finish_up();
  end

  initial begin
    #(CLK_P * 200000);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_up();
  end

endmodule